// File: doc/BRIEF.md
# Masked Nested Interrupt Controller

This block collects interrupt requests from a set of peripherals and from two core-level sources, an emulation break and a power-down request. It holds them in a pending register that software can also set and clear bit by bit. Each peripheral bit is qualified by a mask register and by a global enable. The power-down source ignores the mask but still needs the global enable. The emulation source ignores both. Of the requests that are still eligible, the one with the lowest vector number wins. The block offers that vector to the core.

The core acknowledges the offered vector with a strobe. The block then clears that pending bit and pushes the vector onto an in-service stack. A return strobe pops the stack and restores the previous service level. A runtime control bit chooses between two servicing modes. In nested mode, a strictly higher-priority request may preempt the one in service. In sequential mode, nothing new is offered until the return arrives. After reset both the global enable and nesting are off, and the mask is clear.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset the pending register is all zero, the mask and both control bits are zero, no vector is offered and nothing is in service.
- R2: A high peripheral or core request line, or a `pend_set` bit, sets the matching pending bit at the next clock edge. A `pend_clr` bit clears it. When a bit is set and cleared in the same cycle, the set wins.
- R3: Peripheral k (vector 2+k) is eligible only when its pending bit is set, mask bit k is 1 and the global enable is 1.
- R4: The emulation source (vector 0) is eligible whenever it is pending, whatever the mask or global enable. The power-down source (vector 1) ignores the mask but needs the global enable.
- R5: Vectors are numbered 0 for emulation, 1 for power-down and 2+k for peripheral k. Among the eligible requests, the lowest vector number is offered on `irq_vec`.
- R6: If `irq_ack` is high while `irq_valid` is high, then at that edge the offered vector's pending bit clears. The vector also becomes `svc_vec`, and `svc_active` rises.
- R7: While nesting is disabled (control bit 4 = 0), `irq_valid` stays low whenever something is in service.
- R8: While nesting is enabled, a vector is offered during service only if its number is strictly lower than `svc_vec`.
- R9: `rti` pops the in-service stack, so `svc_vec` returns to the level that was preempted. `svc_active` falls when the stack empties. `rti` with nothing in service has no effect.
- R10: A write with `ctrl_we` loads the global enable from `ctrl_wdata` bit 5 and the nesting enable from bit 4. A write with `mask_we` loads the mask from `mask_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| periph_req | input | NPERIPH | Peripheral request lines, bit k is vector 2+k |
| emu_req | input | 1 | Emulation request (vector 0) |
| pwrdn_req | input | 1 | Power-down request (vector 1) |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 16 | Control data: bit 5 global enable, bit 4 nesting enable |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | NPERIPH | New mask, bit k enables peripheral k |
| pend_set | input | NPERIPH+2 | Software force of pending bits, indexed by vector |
| pend_clr | input | NPERIPH+2 | Software clear of pending bits, indexed by vector |
| irq_valid | output | 1 | A vector is offered to the core |
| irq_vec | output | clog2(NPERIPH+2) | Offered vector number |
| irq_ack | input | 1 | Core takes the offered vector |
| rti | input | 1 | Return from the current service routine |
| pending | output | NPERIPH+2 | Pending register, indexed by vector |
| svc_active | output | 1 | At least one vector is in service |
| svc_vec | output | clog2(NPERIPH+2) | Vector at the top of the in-service stack |

## Verification
The hardest state to reach is a two-deep preemption that then unwinds. One vector is in service, a higher one preempts it, and a lower-priority request waits underneath both. After the first return, the waiting request must still be held off by the restored level. The directed sequence enables nesting and takes a mid-priority peripheral. It then sets a lower one, which must not be offered, and a higher one, which must be. The higher one is acknowledged. Two returns follow, and the bench checks `svc_vec`, `irq_valid` and `irq_vec` after each return.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
   localparam int CORE_SRCS = 2;
   localparam int VEC_EMU   = 0;
   localparam int VEC_PWRDN = 1;
   localparam int CTRL_W    = 16;
   localparam int BIT_NEST  = 4;
   localparam int BIT_GIE   = 5;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
   parameter int NSRC = 17
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] hw_req,
   input  logic [NSRC-1:0] sw_set,
   input  logic [NSRC-1:0] sw_clr,
   input  logic [NSRC-1:0] ack_clr,
   output logic [NSRC-1:0] pend
);
   // new requests take precedence over clears in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~(sw_clr | ack_clr)) | hw_req | sw_set;
   end
endmodule

// File: rtl/irq_elig.sv
module irq_elig
   import irq_nest_pkg::*;
#(
   parameter int NPERIPH = 15,
   localparam int NSRC   = NPERIPH + CORE_SRCS
) (
   input  logic [NSRC-1:0]    pend,
   input  logic [NPERIPH-1:0] mask,
   input  logic               gie,
   output logic [NSRC-1:0]    elig
);
   assign elig[VEC_EMU]   = pend[VEC_EMU];
   assign elig[VEC_PWRDN] = pend[VEC_PWRDN] & gie;
   for (genvar k = 0; k < NPERIPH; k++) begin : g_periph
      assign elig[k + CORE_SRCS] = pend[k + CORE_SRCS] & mask[k] & gie;
   end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N    = 17,
   parameter int IMPL = 0,
   localparam int VW  = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [VW-1:0] idx
);
   assign found = |req;
   if (IMPL == 0) begin : g_scan
      always_comb begin
         idx = '0;
         for (int i = N - 1; i >= 0; i--)
            if (req[i]) idx = VW'(i);
      end
   end else begin : g_isolate
      logic [N-1:0] lowest;
      assign lowest = req & (~req + N'(1));
      always_comb begin
         idx = '0;
         for (int i = 0; i < N; i++)
            if (lowest[i]) idx = idx | VW'(i);
      end
   end
endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack #(
   parameter int DEPTH = 17,
   parameter int VW    = 5,
   localparam int DW   = $clog2(DEPTH + 1),
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [VW-1:0] push_vec,
   input  logic          pop,
   output logic          active,
   output logic          full,
   output logic [VW-1:0] top
);
   logic [VW-1:0] stk [DEPTH];
   logic [DW-1:0] depth;
   logic [DW-1:0] wr_ptr;
   logic          pop_ok;
   logic          push_ok;

   assign active  = (depth != '0);
   assign full    = (depth == DW'(DEPTH));
   assign pop_ok  = pop & active;
   assign push_ok = push & (!full | pop_ok);
   assign wr_ptr  = depth - DW'(pop_ok);
   assign top     = active ? stk[AW'(depth - DW'(1))] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         depth <= '0;
      end else begin
         depth <= depth + DW'(push_ok) - DW'(pop_ok);
         if (push_ok) stk[AW'(wr_ptr)] <= push_vec;
      end
   end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
   import irq_nest_pkg::*;
#(
   parameter int NPERIPH     = 15,
   parameter int STACK_DEPTH = NPERIPH + 2,
   parameter int PICK_IMPL   = 0,
   localparam int NSRC       = NPERIPH + 2,
   localparam int VW         = $clog2(NPERIPH + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NPERIPH-1:0] periph_req,
   input  logic               emu_req,
   input  logic               pwrdn_req,
   input  logic               ctrl_we,
   input  logic [15:0]        ctrl_wdata,
   input  logic               mask_we,
   input  logic [NPERIPH-1:0] mask_wdata,
   input  logic [NSRC-1:0]    pend_set,
   input  logic [NSRC-1:0]    pend_clr,
   output logic               irq_valid,
   output logic [VW-1:0]      irq_vec,
   input  logic               irq_ack,
   input  logic               rti,
   output logic [NSRC-1:0]    pending,
   output logic               svc_active,
   output logic [VW-1:0]      svc_vec
);
   if (NPERIPH < 1)     begin : g_bad_np  $error("NPERIPH must be at least 1");  end
   if (STACK_DEPTH < 1) begin : g_bad_sd  $error("STACK_DEPTH must be at least 1"); end
   if (PICK_IMPL != 0 && PICK_IMPL != 1) begin : g_bad_pi $error("PICK_IMPL must be 0 or 1"); end

   logic               gie_q;
   logic               nest_q;
   logic [NPERIPH-1:0] mask_q;
   logic [NSRC-1:0]    hw_req;
   logic [NSRC-1:0]    ack_clr;
   logic [NSRC-1:0]    elig;
   logic               cand_found;
   logic [VW-1:0]      cand_vec;
   logic               stk_full;
   logic               may_take;
   logic               ack_fire;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gie_q  <= 1'b0;
         nest_q <= 1'b0;
         mask_q <= '0;
      end else begin
         if (ctrl_we) begin
            gie_q  <= ctrl_wdata[BIT_GIE];
            nest_q <= ctrl_wdata[BIT_NEST];
         end
         if (mask_we) mask_q <= mask_wdata;
      end
   end

   assign hw_req = {periph_req, pwrdn_req, emu_req};

   irq_pend_reg #(.NSRC(NSRC)) u_pend (
      .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_set(pend_set),
      .sw_clr(pend_clr), .ack_clr(ack_clr), .pend(pending)
   );

   irq_elig #(.NPERIPH(NPERIPH)) u_elig (
      .pend(pending), .mask(mask_q), .gie(gie_q), .elig(elig)
   );

   irq_prio_pick #(.N(NSRC), .IMPL(PICK_IMPL)) u_pick (
      .req(elig), .found(cand_found), .idx(cand_vec)
   );

   // sequential mode blocks everything while in service; nested needs strictly higher priority
   assign may_take  = !stk_full && (!svc_active || (nest_q && (cand_vec < svc_vec)));
   assign irq_valid = cand_found && may_take;
   assign irq_vec   = cand_vec;
   assign ack_fire  = irq_ack && irq_valid;
   assign ack_clr   = ack_fire ? (NSRC'(1) << cand_vec) : '0;

   irq_svc_stack #(.DEPTH(STACK_DEPTH), .VW(VW)) u_stack (
      .clk(clk), .rst_n(rst_n), .push(ack_fire), .push_vec(cand_vec),
      .pop(rti), .active(svc_active), .full(stk_full), .top(svc_vec)
   );
endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk #(
   parameter int NPERIPH = 15,
   localparam int NSRC   = NPERIPH + 2,
   localparam int VW     = $clog2(NPERIPH + 2)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               irq_valid,
   input logic [VW-1:0]      irq_vec,
   input logic               irq_ack,
   input logic               rti,
   input logic [NSRC-1:0]    pending,
   input logic               svc_active,
   input logic [VW-1:0]      svc_vec,
   input logic               gie,
   input logic               nest_en,
   input logic [NPERIPH-1:0] mask
);
   logic mask_ok;
   always_comb begin
      mask_ok = 1'b1;
      if (irq_vec >= VW'(2)) mask_ok = mask[irq_vec - VW'(2)];
   end

   assert_offer_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> pending[irq_vec]);
   assert_periph_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && irq_vec >= VW'(2)) |-> (gie && mask_ok));
   assert_pwrdn_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && irq_vec == VW'(1)) |-> gie);
   assert_ack_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && irq_ack) |=> (svc_active && svc_vec == $past(irq_vec)));
   assert_seq_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_active && !nest_en) |-> !irq_valid);
   assert_strict_preempt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_active && irq_valid) |-> (irq_vec < svc_vec));
   assert_rti_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rti && !svc_active && !(irq_valid && irq_ack)) |=> !svc_active);
endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(.NPERIPH(NPERIPH)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_vec(irq_vec),
   .irq_ack(irq_ack), .rti(rti), .pending(pending), .svc_active(svc_active),
   .svc_vec(svc_vec), .gie(gie_q), .nest_en(nest_q), .mask(mask_q)
);

// File: tb/irq_nest_ctrl_test.sv
`timescale 1ns/1ps
module irq_nest_ctrl_test;
   localparam int NP = 15;
   localparam int NS = NP + 2;
   localparam int VW = $clog2(NS);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] periph_req = '0;
   logic          emu_req = 1'b0, pwrdn_req = 1'b0;
   logic          ctrl_we = 1'b0, mask_we = 1'b0;
   logic [15:0]   ctrl_wdata = '0;
   logic [NP-1:0] mask_wdata = '0;
   logic [NS-1:0] pend_set = '0, pend_clr = '0;
   logic          irq_valid, irq_ack = 1'b0, rti = 1'b0;
   logic [VW-1:0] irq_vec, svc_vec;
   logic [NS-1:0] pending;
   logic          svc_active;

   int checks = 0;
   int failures = 0;

   irq_nest_ctrl uut (
      .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .emu_req(emu_req),
      .pwrdn_req(pwrdn_req), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .mask_we(mask_we), .mask_wdata(mask_wdata), .pend_set(pend_set),
      .pend_clr(pend_clr), .irq_valid(irq_valid), .irq_vec(irq_vec),
      .irq_ack(irq_ack), .rti(rti), .pending(pending),
      .svc_active(svc_active), .svc_vec(svc_vec)
   );

   always #4 clk = ~clk;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic wr_ctrl(input bit nest, input bit gie);
      ctrl_wdata = '0; ctrl_wdata[4] = nest; ctrl_wdata[5] = gie;
      ctrl_we = 1'b1; tick(); ctrl_we = 1'b0;
   endtask

   task automatic wr_mask(input logic [NP-1:0] m);
      mask_wdata = m; mask_we = 1'b1; tick(); mask_we = 1'b0;
   endtask

   task automatic sset(input int v);
      pend_set = '0; pend_set[v] = 1'b1; tick(); pend_set = '0;
   endtask

   task automatic sclr(input int v);
      pend_clr = '0; pend_clr[v] = 1'b1; tick(); pend_clr = '0;
   endtask

   task automatic do_ack();
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
   endtask

   task automatic do_rti();
      rti = 1'b1; tick(); rti = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 pending", int'(pending), 0);
      chk("R1 valid", int'(irq_valid), 0);
      chk("R1 active", int'(svc_active), 0);
      periph_req[0] = 1'b1; tick(); periph_req[0] = 1'b0;
      chk("R2 hw latch", int'(pending), 4);
      chk("R1 gie off blocks", int'(irq_valid), 0);
      sclr(2);
   endtask

   task automatic t_pend();
      sset(5);
      chk("R2 sw set", int'(pending), 32);
      sclr(5);
      chk("R2 sw clr", int'(pending), 0);
      pend_set[6] = 1'b1; pend_clr[6] = 1'b1; tick();
      pend_set = '0; pend_clr = '0;
      chk("R2 set wins", int'(pending[6]), 1);
      sclr(6);
   endtask

   task automatic t_mask();
      wr_ctrl(1'b0, 1'b1);
      sset(5);
      chk("R3 masked", int'(irq_valid), 0);
      wr_mask(NP'(1) << 3);
      chk("R3 unmasked valid", int'(irq_valid), 1);
      chk("R3 unmasked vec", int'(irq_vec), 5);
      wr_ctrl(1'b0, 1'b0);
      chk("R10 gie cleared", int'(irq_valid), 0);
      sclr(5); wr_mask('0);
   endtask

   task automatic t_core();
      sset(1);
      chk("R4 pwrdn needs gie", int'(irq_valid), 0);
      wr_ctrl(1'b0, 1'b1);
      chk("R4 pwrdn valid", int'(irq_valid), 1);
      chk("R4 pwrdn vec", int'(irq_vec), 1);
      sclr(1); wr_ctrl(1'b0, 1'b0);
      emu_req = 1'b1; tick(); emu_req = 1'b0;
      chk("R4 emu bypass", int'(irq_valid), 1);
      chk("R4 emu vec", int'(irq_vec), 0);
      sclr(0);
   endtask

   task automatic t_prio();
      wr_ctrl(1'b0, 1'b1); wr_mask('1);
      pend_set = '0; pend_set[9] = 1'b1; pend_set[4] = 1'b1; pend_set[16] = 1'b1;
      tick(); pend_set = '0;
      chk("R5 lowest vec", int'(irq_vec), 4);
      sclr(4);
      chk("R5 next vec", int'(irq_vec), 9);
      sclr(9);
      chk("R5 last vec", int'(irq_vec), 16);
      sset(1);
      chk("R5 pwrdn over periph", int'(irq_vec), 1);
      sclr(1); sclr(16);
   endtask

   task automatic t_ack();
      sset(6);
      do_ack();
      chk("R6 pending cleared", int'(pending[6]), 0);
      chk("R6 active", int'(svc_active), 1);
      chk("R6 svc vec", int'(svc_vec), 6);
      do_rti();
      chk("R9 popped", int'(svc_active), 0);
   endtask

   task automatic t_seq();
      sset(6); do_ack();
      sset(2);
      chk("R7 seq blocks higher", int'(irq_valid), 0);
      do_rti();
      chk("R7 after rti valid", int'(irq_valid), 1);
      chk("R7 after rti vec", int'(irq_vec), 2);
      do_ack(); do_rti();
   endtask

   task automatic t_nest();
      wr_ctrl(1'b1, 1'b1);
      sset(7); do_ack();
      sset(11);
      chk("R8 lower held", int'(irq_valid), 0);
      sset(7);
      chk("R8 equal held", int'(irq_valid), 0);
      sclr(7);
      sset(3);
      chk("R8 higher offered", int'(irq_valid), 1);
      chk("R8 higher vec", int'(irq_vec), 3);
      do_ack();
      chk("R8 preempt svc", int'(svc_vec), 3);
      do_rti();
      chk("R9 restored vec", int'(svc_vec), 7);
      chk("R9 still active", int'(svc_active), 1);
      chk("R9 lower still held", int'(irq_valid), 0);
      do_rti();
      chk("R9 empty", int'(svc_active), 0);
      chk("R9 waiting vec", int'(irq_vec), 11);
      do_ack(); do_rti();
      do_rti();
      chk("R9 rti on empty", int'(svc_active), 0);
      chk("R9 rti on empty valid", int'(irq_valid), 0);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_pend();
      t_mask();
      t_core();
      t_prio();
      t_ack();
      t_seq();
      t_nest();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule